// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

A single DMA channel driven entirely by control blocks that sit in memory. Software writes the byte address of the first block into the block-address register and then sets the run bit in the control/status register. The channel reads the eight-word block and then moves 32-bit words from the source address to the destination address until the block's byte count is used up. It then continues with the block named by the block's link word. A zero link ends the chain. A link that points back to an earlier block gives an endless ring, which suits audio-style cyclic buffers.

Each block carries its own settings word. That word chooses whether the source and destination advance, whether either side waits on a peripheral request line (and which line), and whether finishing the block raises the interrupt. One word-wide memory port serves both descriptor reads and data moves. Software can clear the run bit to pause the channel, issue an abort that drops the current block and follows its link, or issue a channel reset.

Top module: `dcc_top`

## Requirements
- R1: After reset, the status word at offset 0x00 reads 0x0000_0010 (run bit 0 clear, paused bit 4 set), `irq` is low and `mem_req` is low.
- R2: When the run bit (bit 0 of 0x00) is written to 1 while the channel is idle, the channel reads the eight words at the block address (written at 0x04) in ascending order. Word 0 is the settings word, word 1 the source, word 2 the destination, word 3 the byte count and word 5 the link. The channel then performs count/4 read-then-write element moves.
- R3: Settings bit 8 makes the source advance by 4 after each element, and settings bit 4 does the same for the destination. When the bit is clear, that address stays fixed for the whole block.
- R4: When a block ends with a nonzero link, the channel fetches the block at the link address. When the link is zero, the run bit clears and the channel stops.
- R5: When a block completes and settings bit 0 is set, status bit 2 and `irq` go high. Writing 1 to status bit 2 clears them. If a clear and a completion fall in the same cycle, the flag stays set.
- R6: Settings bit 10 paces source reads and bit 6 paces destination writes on the `dreq` line selected by settings bits 20:16. A paced access is not issued while that line is low, and status bit 5 reads 1 while the channel waits on it.
- R7: Writing 0 to the run bit stops new memory accesses once any access in flight has finished, and status bit 4 reads 1. Writing 1 again resumes, and the block completes with correct data.
- R8: Writing bit 30 together with bit 0 of the status word ends the current block without further data moves and follows the link register at 0x1C. Software can write that register to 0 first to stop the chain.
- R9: Writing bit 31 of the status word returns the channel to idle at the next clock edge, with run, the interrupt flag and the error bit cleared and no memory request.
- R10: A block with a byte count of zero completes right after its fetch, with no data access, and still raises the interrupt if enabled.
- R11: A byte count that is not a multiple of 4 sets error bit 8 and clears the run bit, and no data is moved.
- R12: Offsets 0x0C and 0x10 read the live source and destination addresses, which after a block equal the start address plus 4 per element on an advancing side, or the start address on a fixed side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes in this cycle |
| dreq | input | DREQ_N | Peripheral request lines |
| irq | output | 1 | Interrupt, mirrors status bit 2 |

## Verification
Two updates can hit the interrupt flag in the same clock edge: the acknowledge of a block's final write sets it, and a software write of 1 to bit 2 clears it. The bench turns on immediate acknowledges and watches the memory port at each falling edge. When it sees the final write request of an interrupt-enabled block, it drives the clearing write in that same cycle, so both land on one edge. It then expects the flag and `irq` to remain high, because a lost completion would be the worse outcome.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int DW = 32;
  localparam int RAW = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_READ,
    ST_WRITE,
    ST_NEXT
  } eng_st_t;

  // settings word fields
  localparam int TI_IRQ_EN   = 0;
  localparam int TI_DST_INC  = 4;
  localparam int TI_DST_PACE = 6;
  localparam int TI_SRC_INC  = 8;
  localparam int TI_SRC_PACE = 10;
  localparam int TI_SEL_LO   = 16;
  localparam int TI_SEL_HI   = 20;

  // status word fields
  localparam int CS_RUN    = 0;
  localparam int CS_INT    = 2;
  localparam int CS_PAUSED = 4;
  localparam int CS_HELD   = 5;
  localparam int CS_ERR    = 8;
  localparam int CS_ABORT  = 30;
  localparam int CS_RESET  = 31;

  localparam logic [RAW-1:0] RA_CS  = 5'h00;
  localparam logic [RAW-1:0] RA_CB  = 5'h04;
  localparam logic [RAW-1:0] RA_TI  = 5'h08;
  localparam logic [RAW-1:0] RA_SRC = 5'h0C;
  localparam logic [RAW-1:0] RA_DST = 5'h10;
  localparam logic [RAW-1:0] RA_LEN = 5'h14;
  localparam logic [RAW-1:0] RA_NXT = 5'h1C;

  localparam int CB_WORDS = 8;
  localparam int CBI_W = $clog2(CB_WORDS);

  function automatic logic [DW-1:0] step_addr(input logic [DW-1:0] a, input logic inc);
    return inc ? a + DW'(4) : a;
  endfunction

  function automatic logic [DW-1:0] cb_word_addr(input logic [DW-1:0] base,
                                                 input logic [CBI_W-1:0] idx);
    return base + DW'({idx, 2'b00});
  endfunction

  function automatic logic last_elem(input logic [DW-1:0] left);
    return left <= DW'(4);
  endfunction
endpackage

// File: rtl/dcc_engine.sv
module dcc_engine
  import dcc_pkg::*;
#(
  parameter int DREQ_N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              run,
  input  logic              abort_req,
  input  logic              cb_wr,
  input  logic [DW-1:0]     cb_wdata,
  input  logic              nx_wr,
  input  logic [DW-1:0]     nx_wdata,
  input  logic [DREQ_N-1:0] dreq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ack,
  output logic [DW-1:0]     cb_addr_o,
  output logic [DW-1:0]     ti_o,
  output logic [DW-1:0]     src_o,
  output logic [DW-1:0]     dst_o,
  output logic [DW-1:0]     len_o,
  output logic [DW-1:0]     nxt_o,
  output logic              held,
  output logic              blk_irq,
  output logic              chain_end,
  output logic              len_err
);
  eng_st_t          st_q;
  logic [CBI_W-1:0] fidx_q;
  logic             busy_q, abort_pend_q;
  logic [DW-1:0]    cb_q, ti_q, src_q, dst_q, len_q, nxt_q, data_q;

  logic [31:0] dreq_pad;
  logic        dreq_hit, pace_wait, in_xfer, can_issue, acc_done;
  logic        fetch_last, write_last, zero_blk, blk_fin, aborting;

  assign dreq_pad   = 32'(dreq);
  assign dreq_hit   = dreq_pad[ti_q[TI_SEL_HI:TI_SEL_LO]];
  assign pace_wait  = ((st_q == ST_READ)  && ti_q[TI_SRC_PACE] && !dreq_hit) ||
                      ((st_q == ST_WRITE) && ti_q[TI_DST_PACE] && !dreq_hit);
  assign in_xfer    = (st_q == ST_FETCH) || (st_q == ST_READ) || (st_q == ST_WRITE);
  assign can_issue  = in_xfer && run && !abort_pend_q && !pace_wait && !busy_q;
  assign mem_req    = busy_q || can_issue;
  assign acc_done   = mem_req && mem_ack;
  assign held       = pace_wait && run && !busy_q;
  assign aborting   = abort_pend_q && in_xfer && !busy_q;

  assign fetch_last = (st_q == ST_FETCH) && acc_done && (fidx_q == CBI_W'(CB_WORDS - 1));
  assign len_err    = fetch_last && (len_q[1:0] != 2'b00);
  assign zero_blk   = fetch_last && (len_q == '0);
  assign write_last = (st_q == ST_WRITE) && acc_done && last_elem(len_q);
  assign blk_fin    = zero_blk || write_last;
  assign blk_irq    = blk_fin && ti_q[TI_IRQ_EN];
  assign chain_end  = (st_q == ST_NEXT) && (nxt_q == '0);

  assign mem_we    = (st_q == ST_WRITE);
  assign mem_wdata = data_q;
  always_comb begin
    case (st_q)
      ST_READ:  mem_addr = src_q;
      ST_WRITE: mem_addr = dst_q;
      default:  mem_addr = cb_word_addr(cb_q, fidx_q);
    endcase
  end

  assign cb_addr_o = cb_q;
  assign ti_o      = ti_q;
  assign src_o     = src_q;
  assign dst_o     = dst_q;
  assign len_o     = len_q;
  assign nxt_o     = nxt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; fidx_q <= '0; busy_q <= 1'b0; abort_pend_q <= 1'b0;
      cb_q <= '0; ti_q <= '0; src_q <= '0; dst_q <= '0; len_q <= '0;
      nxt_q <= '0; data_q <= '0;
    end else if (soft_rst) begin
      st_q <= ST_IDLE; fidx_q <= '0; busy_q <= 1'b0; abort_pend_q <= 1'b0;
    end else begin
      busy_q <= mem_req && !mem_ack;
      if (abort_req && st_q != ST_IDLE) abort_pend_q <= 1'b1;
      if (cb_wr && st_q == ST_IDLE) cb_q <= cb_wdata;
      if (nx_wr) nxt_q <= nx_wdata;
      case (st_q)
        ST_IDLE: begin
          abort_pend_q <= 1'b0;
          if (run) begin
            st_q   <= ST_FETCH;
            fidx_q <= '0;
          end
        end
        ST_FETCH: begin
          if (aborting) begin
            st_q <= ST_NEXT;
            abort_pend_q <= 1'b0;
          end else if (acc_done) begin
            case (fidx_q)
              CBI_W'(0): ti_q  <= mem_rdata;
              CBI_W'(1): src_q <= mem_rdata;
              CBI_W'(2): dst_q <= mem_rdata;
              CBI_W'(3): len_q <= mem_rdata;
              CBI_W'(5): nxt_q <= mem_rdata;
              default: ;
            endcase
            fidx_q <= fidx_q + CBI_W'(1);
            if (fetch_last) begin
              if (len_err)       st_q <= ST_IDLE;
              else if (zero_blk) st_q <= ST_NEXT;
              else               st_q <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (aborting) begin
            st_q <= ST_NEXT;
            abort_pend_q <= 1'b0;
          end else if (acc_done) begin
            data_q <= mem_rdata;
            src_q  <= step_addr(src_q, ti_q[TI_SRC_INC]);
            st_q   <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (aborting) begin
            st_q <= ST_NEXT;
            abort_pend_q <= 1'b0;
          end else if (acc_done) begin
            dst_q <= step_addr(dst_q, ti_q[TI_DST_INC]);
            if (write_last) begin
              len_q <= '0;
              st_q  <= ST_NEXT;
            end else begin
              len_q <= len_q - DW'(4);
              st_q  <= ST_READ;
            end
          end
        end
        ST_NEXT: begin
          abort_pend_q <= 1'b0;
          if (nxt_q != '0) begin
            cb_q   <= nxt_q;
            fidx_q <= '0;
            st_q   <= ST_FETCH;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ($stable(mem_addr) && $stable(mem_we)));

  // R6
  pace_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !mem_req);

  // R7
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !busy_q) |-> !mem_req);

  // R11
  err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_err && !soft_rst) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/dcc_csr.sv
module dcc_csr
  import dcc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_wr,
  input  logic [DW-1:0] wdata,
  input  logic          blk_irq,
  input  logic          chain_end,
  input  logic          len_err,
  output logic          run_q,
  output logic          int_q,
  output logic          err_q,
  output logic          soft_rst,
  output logic          abort_req
);
  assign soft_rst  = cs_wr && wdata[CS_RESET];
  assign abort_req = cs_wr && !wdata[CS_RESET] && wdata[CS_ABORT] && wdata[CS_RUN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; int_q <= 1'b0; err_q <= 1'b0;
    end else if (soft_rst) begin
      run_q <= 1'b0; int_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (cs_wr) run_q <= wdata[CS_RUN];
      if (chain_end || len_err) run_q <= 1'b0;
      if (cs_wr && wdata[CS_INT]) int_q <= 1'b0;
      if (blk_irq) int_q <= 1'b1;
      if (len_err) err_q <= 1'b1;
    end
  end

  // R5
  int_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_irq && !soft_rst) |=> int_q);

  // R9
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!run_q && !int_q && !err_q));

  // R4
  chain_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_end && !soft_rst) |=> !run_q);
endmodule

// File: rtl/dcc_top.sv
module dcc_top
  import dcc_pkg::*;
#(
  parameter int DREQ_N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ack,
  input  logic [DREQ_N-1:0] dreq,
  output logic              irq
);
  logic cs_wr, cb_wr, nx_wr;
  logic run_q, int_q, err_q, soft_rst, abort_req;
  logic held, blk_irq, chain_end, len_err;
  logic [DW-1:0] cb_addr, ti, src, dst, len, nxt, cs_word;

  assign cs_wr = reg_wr && (reg_addr == RA_CS);
  assign cb_wr = reg_wr && (reg_addr == RA_CB);
  assign nx_wr = reg_wr && (reg_addr == RA_NXT);

  dcc_csr u_csr (
    .clk, .rst_n, .cs_wr, .wdata(reg_wdata), .blk_irq, .chain_end, .len_err,
    .run_q, .int_q, .err_q, .soft_rst, .abort_req
  );

  dcc_engine #(.DREQ_N(DREQ_N)) u_eng (
    .clk, .rst_n, .soft_rst, .run(run_q), .abort_req,
    .cb_wr, .cb_wdata(reg_wdata), .nx_wr, .nx_wdata(reg_wdata), .dreq,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack,
    .cb_addr_o(cb_addr), .ti_o(ti), .src_o(src), .dst_o(dst), .len_o(len), .nxt_o(nxt),
    .held, .blk_irq, .chain_end, .len_err
  );

  always_comb begin
    cs_word            = '0;
    cs_word[CS_RUN]    = run_q;
    cs_word[CS_INT]    = int_q;
    cs_word[CS_PAUSED] = !run_q;
    cs_word[CS_HELD]   = held;
    cs_word[CS_ERR]    = err_q;
  end

  always_comb begin
    case (reg_addr)
      RA_CS:   reg_rdata = cs_word;
      RA_CB:   reg_rdata = cb_addr;
      RA_TI:   reg_rdata = ti;
      RA_SRC:  reg_rdata = src;
      RA_DST:  reg_rdata = dst;
      RA_LEN:  reg_rdata = len;
      RA_NXT:  reg_rdata = nxt;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = int_q;
endmodule

// File: tb/dcc_top_bench.sv
module dcc_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] dreq = '0;
  logic        irq;

  logic [31:0] mem [0:1023];
  logic        ack_rand = 1'b0;
  logic        ack_gate = 1'b1;
  int n_chk = 0, n_err = 0, rd_cnt = 0, wr_cnt = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcc_top u_dcc_top (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack,
    .dreq, .irq
  );

  assign mem_ack   = mem_req & ack_gate;
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(negedge clk) ack_gate <= ack_rand ? ($urandom_range(0, 3) != 0) : 1'b1;

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        mem[mem_addr[11:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] mk_ti(input bit ie, input bit dinc, input bit dpace,
                                        input bit sinc, input bit space, input int sel);
    return (32'(ie)) | (32'(dinc) << 4) | (32'(dpace) << 6) | (32'(sinc) << 8) |
           (32'(space) << 10) | (32'(sel & 31) << 16);
  endfunction

  // byte address of element i on one side of a block
  function automatic logic [31:0] elem_at(input logic [31:0] base, input bit inc, input int i);
    return inc ? base + 32'(4 * i) : base;
  endfunction

  task automatic put_cb(input logic [31:0] cb, input logic [31:0] ti, input logic [31:0] s,
                        input logic [31:0] d, input logic [31:0] len, input logic [31:0] nx);
    int w = int'(cb[11:2]);
    mem[w] = ti; mem[w+1] = s; mem[w+2] = d; mem[w+3] = len;
    mem[w+4] = 32'h0; mem[w+5] = nx; mem[w+6] = 32'h0; mem[w+7] = 32'h0;
  endtask

  task automatic prep(input logic [31:0] s, input logic [31:0] d, input int n);
    for (int i = 0; i < 40; i++) begin
      mem[s[11:2] + 10'(i)] = $urandom;
      mem[d[11:2] + 10'(i)] = SENT;
    end
  endtask

  task automatic start(input logic [31:0] cb);
    wr_reg(5'h04, cb);
    wr_reg(5'h00, 32'h1);
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] v;
    bit done = 0;
    for (int k = 0; k < 3000 && !done; k++) begin
      rd_reg(5'h00, v);
      if (!v[0]) done = 1;
    end
    if (!done) chk({req, " channel never stopped"}, 32'h1, 32'h0);
  endtask

  task automatic check_copy(input string req, input logic [31:0] s, input logic [31:0] d,
                            input bit sinc, input bit dinc, input int n);
    if (dinc) begin
      for (int i = 0; i < n; i++)
        chk(req, mem[elem_at(d, 1, i) >> 2], mem[elem_at(s, sinc, i) >> 2]);
      chk({req, " past end"}, mem[elem_at(d, 1, n) >> 2], SENT);
    end else if (n > 0) begin
      chk(req, mem[d >> 2], mem[elem_at(s, sinc, n - 1) >> 2]);
      chk({req, " neighbour"}, mem[(d >> 2) + 1], SENT);
    end
  endtask

  initial begin
    logic [31:0] v;
    int r0, w0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd_reg(5'h00, v);
    chk("R1 status", v, 32'h10);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 mem_req", 32'(mem_req), 32'h0);

    // R2 R5: basic block with interrupt
    prep(32'h400, 32'h800, 4);
    put_cb(32'h0, mk_ti(1, 1, 0, 1, 0, 0), 32'h400, 32'h800, 32'd16, 32'h0);
    r0 = rd_cnt; w0 = wr_cnt;
    start(32'h0);
    wait_idle("R2");
    check_copy("R2 data", 32'h400, 32'h800, 1, 1, 4);
    chk("R2 reads", 32'(rd_cnt - r0), 32'd12);
    chk("R2 writes", 32'(wr_cnt - w0), 32'd4);
    chk("R5 irq set", 32'(irq), 32'h1);
    rd_reg(5'h00, v);
    chk("R4 stopped status", v, 32'h14);
    wr_reg(5'h00, 32'h4);
    chk("R5 irq cleared", 32'(irq), 32'h0);

    // R3 R12: fixed destination
    prep(32'h400, 32'h800, 3);
    put_cb(32'h0, mk_ti(0, 0, 0, 1, 0, 0), 32'h400, 32'h800, 32'd12, 32'h0);
    start(32'h0);
    wait_idle("R3");
    check_copy("R3 fixed dst", 32'h400, 32'h800, 1, 0, 3);
    rd_reg(5'h0C, v); chk("R12 live src", v, 32'h40C);
    rd_reg(5'h10, v); chk("R12 live dst", v, 32'h800);

    // R4: two linked blocks
    prep(32'h400, 32'h800, 3);
    prep(32'h600, 32'hC00, 2);
    put_cb(32'h0,  mk_ti(0, 1, 0, 1, 0, 0), 32'h400, 32'h800, 32'd12, 32'h40);
    put_cb(32'h40, mk_ti(0, 1, 0, 1, 0, 0), 32'h600, 32'hC00, 32'd8,  32'h0);
    start(32'h0);
    wait_idle("R4");
    check_copy("R4 first", 32'h400, 32'h800, 1, 1, 3);
    check_copy("R4 second", 32'h600, 32'hC00, 1, 1, 2);
    rd_reg(5'h04, v); chk("R4 block address followed link", v, 32'h40);

    // R2 R3 R12: random blocks with random acknowledge gaps
    ack_rand = 1'b1;
    for (int it = 0; it < 16; it++) begin
      int n = $urandom_range(0, 24);
      bit si = 1'($urandom_range(0, 1));
      bit di = 1'($urandom_range(0, 1));
      prep(32'h400, 32'h800, n);
      put_cb(32'h80, mk_ti(0, di, 0, si, 0, 0), 32'h400, 32'h800, 32'(4 * n), 32'h0);
      r0 = rd_cnt; w0 = wr_cnt;
      start(32'h80);
      wait_idle("R2 random");
      check_copy("R3 random data", 32'h400, 32'h800, si, di, n);
      chk("R2 random writes", 32'(wr_cnt - w0), 32'(n));
      chk("R2 random reads", 32'(rd_cnt - r0), 32'(8 + n));
      rd_reg(5'h0C, v); chk("R12 random src", v, elem_at(32'h400, si, n));
      rd_reg(5'h10, v); chk("R12 random dst", v, elem_at(32'h800, di, n));
    end
    ack_rand = 1'b0;

    // R6: source paced on line 5, line 4 high must not release it
    prep(32'h400, 32'h800, 4);
    put_cb(32'h0, mk_ti(0, 1, 0, 1, 1, 5), 32'h400, 32'h800, 32'd16, 32'h0);
    dreq = 32'h10;
    r0 = rd_cnt;
    start(32'h0);
    repeat (20) @(negedge clk);
    rd_reg(5'h00, v);
    chk("R6 held status", v, 32'h21);
    chk("R6 no data read", 32'(rd_cnt - r0), 32'd8);
    dreq = 32'h20;
    wait_idle("R6");
    check_copy("R6 data", 32'h400, 32'h800, 1, 1, 4);
    dreq = 32'h0;

    // R7: pause and resume
    prep(32'h400, 32'h800, 32);
    put_cb(32'h0, mk_ti(0, 1, 0, 1, 0, 0), 32'h400, 32'h800, 32'd128, 32'h0);
    w0 = wr_cnt;
    start(32'h0);
    while (wr_cnt - w0 < 3) @(negedge clk);
    wr_reg(5'h00, 32'h0);
    repeat (3) @(negedge clk);
    r0 = rd_cnt + wr_cnt;
    repeat (20) @(negedge clk);
    chk("R7 quiet while paused", 32'(rd_cnt + wr_cnt), 32'(r0));
    rd_reg(5'h00, v);
    chk("R7 paused status", v, 32'h10);
    wr_reg(5'h00, 32'h1);
    wait_idle("R7");
    check_copy("R7 resumed data", 32'h400, 32'h800, 1, 1, 32);

    // R8: abort follows the link
    prep(32'h400, 32'h800, 32);
    prep(32'h600, 32'hC00, 2);
    put_cb(32'h0,  mk_ti(0, 1, 0, 1, 0, 0), 32'h400, 32'h800, 32'd128, 32'h40);
    put_cb(32'h40, mk_ti(1, 1, 0, 1, 0, 0), 32'h600, 32'hC00, 32'd8,  32'h0);
    w0 = wr_cnt;
    start(32'h0);
    while (wr_cnt - w0 < 4) @(negedge clk);
    wr_reg(5'h00, 32'h4000_0001);
    wait_idle("R8");
    chk("R8 aborted block tail untouched", mem[(32'h800 >> 2) + 31], SENT);
    check_copy("R8 linked block ran", 32'h600, 32'hC00, 1, 1, 2);
    chk("R8 linked irq", 32'(irq), 32'h1);
    wr_reg(5'h00, 32'h4);

    // R8: abort after zeroing the link stops the chain
    prep(32'h400, 32'h800, 32);
    prep(32'h600, 32'hC00, 2);
    w0 = wr_cnt;
    start(32'h0);
    while (wr_cnt - w0 < 4) @(negedge clk);
    wr_reg(5'h1C, 32'h0);
    wr_reg(5'h00, 32'h4000_0001);
    wait_idle("R8 stop");
    chk("R8 tail untouched", mem[(32'h800 >> 2) + 31], SENT);
    chk("R8 next block skipped", mem[32'hC00 >> 2], SENT);
    chk("R8 no irq", 32'(irq), 32'h0);

    // R10: zero-length block
    put_cb(32'h0, mk_ti(1, 1, 0, 1, 0, 0), 32'h400, 32'h800, 32'd0, 32'h0);
    r0 = rd_cnt; w0 = wr_cnt;
    start(32'h0);
    wait_idle("R10");
    chk("R10 only fetch reads", 32'(rd_cnt - r0), 32'd8);
    chk("R10 no writes", 32'(wr_cnt - w0), 32'd0);
    chk("R10 irq", 32'(irq), 32'h1);

    // R11: misaligned count (interrupt flag left set from above)
    put_cb(32'h0, mk_ti(0, 1, 0, 1, 0, 0), 32'h400, 32'h800, 32'd6, 32'h0);
    w0 = wr_cnt;
    start(32'h0);
    wait_idle("R11");
    rd_reg(5'h00, v);
    chk("R11 error status", v, 32'h114);
    chk("R11 no writes", 32'(wr_cnt - w0), 32'd0);

    // R9: channel reset mid-block clears run, flag and error
    prep(32'h400, 32'h800, 32);
    put_cb(32'h0, mk_ti(0, 1, 0, 1, 0, 0), 32'h400, 32'h800, 32'd128, 32'h0);
    w0 = wr_cnt;
    start(32'h0);
    while (wr_cnt - w0 < 2) @(negedge clk);
    wr_reg(5'h00, 32'h8000_0000);
    chk("R9 mem_req dropped", 32'(mem_req), 32'h0);
    chk("R9 irq cleared", 32'(irq), 32'h0);
    rd_reg(5'h00, v);
    chk("R9 status", v, 32'h10);

    // R5: clear write and block completion on the same edge
    prep(32'h400, 32'h800, 2);
    put_cb(32'h0, mk_ti(1, 1, 0, 1, 0, 0), 32'h400, 32'h800, 32'd8, 32'h0);
    start(32'h0);
    begin
      bit hit = 0;
      for (int k = 0; k < 200 && !hit; k++) begin
        @(negedge clk);
        if (mem_req && mem_we && mem_addr == 32'h804) hit = 1;
      end
      chk("R5 last write seen", 32'(hit), 32'h1);
      reg_wr = 1'b1; reg_addr = 5'h00; reg_wdata = 32'h5;
      @(negedge clk);
      reg_wr = 1'b0;
    end
    wait_idle("R5");
    chk("R5 set wins over clear", 32'(irq), 32'h1);
    rd_reg(5'h00, v);
    chk("R5 status flag", v, 32'h14);

    summary();
    $finish;
  end
endmodule